// File: doc/BRIEF.md
# Register List Push Sequencer

The block carries out a stack-frame preparation step over several clock cycles. A start request supplies a 12-bit mask that selects registers, a 5-bit frame size and the current stack pointer. For every register selected in the mask, the block reads the register through a register-file read port and writes it as one 32-bit word to memory. Before each write the stack pointer is moved down by four bytes. Once the last register is stored, the block subtracts the zero-extended frame size from the stack pointer and commits the result.

An extended form adds one more cycle, in which the element pointer is loaded from a source picked by a 2-bit selector. The source is the final stack pointer or an immediate word supplied with the request. The block has no other memory traffic and holds no registers beyond the operation in progress. List bit i names general register 20+i. Registers are pushed from the highest-numbered one to the lowest.

The controller has four states. ST_IDLE waits for a request. ST_PUSH stores one word per cycle. ST_ADJUST commits the new stack pointer. ST_EPLOAD commits the element pointer.

The transitions are:
- idle_to_push: start with a non-empty mask.
- idle_to_adjust: start with an empty mask.
- push_stay: bits are still left in the mask.
- push_to_adjust: the last bit has been stored.
- adjust_to_epload: extended form.
- adjust_to_idle: basic form.
- epload_to_idle: always, after the element-pointer load.

Top module: `reglist_push_seq`

## Requirements
- R1: After reset, busy, done, mem_we, sp_we and ep_we are all 0.
- R2: A start accepted in idle with N mask bits set gives exactly N consecutive cycles with mem_we=1, starting the cycle after the start edge. The first write address is sp_in-4, and each following write address is 4 lower than the previous one.
- R3: Each write stores general register 20+i for list bit i: rf_raddr shows that register and mem_wdata carries rf_rdata. Writes run from the highest set bit to the lowest.
- R4: The cycle after the last write (or the cycle after start for an empty mask) has sp_we=1 with sp_out = sp_in - 4*N - zero-extend(frame_imm).
- R5: In the basic form (ext_form=0), busy lasts exactly N+1 cycles and done is 1 only in the sp_we cycle.
- R6: In the extended form (ext_form=1), the cycle after sp_we has ep_we=1 and done=1, and busy lasts exactly N+2 cycles.
- R7: The ep_src selector chooses the element-pointer value:
  - 00: the final stack pointer.
  - 01: ext_imm[15:0], sign-extended.
  - 10: ext_imm[15:0] placed in the upper half, with the lower half zero.
  - 11: ext_imm in full.
- R8: An empty mask gives no memory write and takes 1 cycle (basic form) or 2 cycles (extended form).
- R9: start and all request inputs are ignored while busy. The operation in progress is unchanged, and no new operation follows it.
- R10: done is a single-cycle pulse, and busy is 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; accepted only in idle |
| list_mask | input | 12 | Register selection, bit i names register 20+i |
| frame_imm | input | 5 | Frame size subtracted after the pushes |
| ext_form | input | 1 | 1 selects the extended form with element-pointer load |
| ep_src | input | 2 | Element-pointer source selector |
| ext_imm | input | 32 | Immediate word for the element-pointer load |
| sp_in | input | 32 | Stack pointer at the start of the operation |
| rf_raddr | output | 5 | Register-file read address |
| rf_rdata | input | 32 | Register-file read data, same cycle |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| sp_we | output | 1 | Stack-pointer commit strobe |
| sp_out | output | 32 | New stack-pointer value |
| ep_we | output | 1 | Element-pointer commit strobe |
| ep_out | output | 32 | New element-pointer value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of the operation |

## Verification
The bench targets the following corner cases:
- Sparse masks with gaps, the full 12-bit mask and the empty mask. A faulty picker would store registers out of order or repeat one. A bad exit test would produce one write too many or an empty-mask cycle that writes.
- All four element-pointer selectors, including a negative 16-bit immediate. Here a wrong sign or shift shows as a wrong ep_out.
- A stack pointer near zero so that addresses wrap, and the largest frame size.
- A start raised mid-operation with different request values. A design that reloads its registers while busy would corrupt addresses or data or start a second operation, and the scoreboard would see that.
- The busy cycles counted against N+1 and N+2, which catches a missing or extra state.

// File: rtl/rlp_pkg.sv
`timescale 1ns/1ps
package rlp_pkg;
    localparam int LIST_W   = 12;
    localparam int DATA_W   = 32;
    localparam int REG_AW   = 5;
    localparam int REG_BASE = 20;
    localparam int IMM_W    = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_ADJUST,
        ST_EPLOAD
    } seq_state_t;
endpackage

// File: rtl/rlp_hi_pick.sv
`timescale 1ns/1ps
module rlp_hi_pick #(
    parameter int W     = 12,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic [IDX_W-1:0] idx,
    output logic             vld
);
    // the highest set bit wins because later iterations overwrite
    always_comb begin
        idx = '0;
        vld = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
                vld = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rlp_ep_src.sv
`timescale 1ns/1ps
module rlp_ep_src #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] sp_val,
    input  logic [DATA_W-1:0] imm_val,
    output logic [DATA_W-1:0] ep_val
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        unique case (sel)
            2'b00:   ep_val = sp_val;
            2'b01:   ep_val = {{(DATA_W-HALF){imm_val[HALF-1]}}, imm_val[HALF-1:0]};
            2'b10:   ep_val = {imm_val[HALF-1:0], {(DATA_W-HALF){1'b0}}};
            default: ep_val = imm_val;
        endcase
    end
endmodule

// File: rtl/reglist_push_seq.sv
`timescale 1ns/1ps
module reglist_push_seq
    import rlp_pkg::*;
#(
    parameter int L_W        = LIST_W,
    parameter int D_W        = DATA_W,
    parameter int RA_W       = REG_AW,
    parameter int R_BASE     = REG_BASE,
    parameter int I_W        = IMM_W,
    parameter int WORD_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [L_W-1:0]  list_mask,
    input  logic [I_W-1:0]  frame_imm,
    input  logic            ext_form,
    input  logic [1:0]      ep_src,
    input  logic [D_W-1:0]  ext_imm,
    input  logic [D_W-1:0]  sp_in,
    output logic [RA_W-1:0] rf_raddr,
    input  logic [D_W-1:0]  rf_rdata,
    output logic            mem_we,
    output logic [D_W-1:0]  mem_addr,
    output logic [D_W-1:0]  mem_wdata,
    output logic            sp_we,
    output logic [D_W-1:0]  sp_out,
    output logic            ep_we,
    output logic [D_W-1:0]  ep_out,
    output logic            busy,
    output logic            done
);
    localparam int IDX_W = $clog2(L_W);

    seq_state_t     state_q, state_d;
    logic [L_W-1:0] left_q;
    logic [I_W-1:0] imm_q;
    logic           ext_q;
    logic [1:0]     sel_q;
    logic [D_W-1:0] sp_q;
    logic [D_W-1:0] immv_q;

    logic [IDX_W-1:0] pick_idx;
    logic             pick_vld;
    logic [L_W-1:0]   left_clr;
    logic [D_W-1:0]   sp_adj;

    rlp_hi_pick #(.W(L_W), .IDX_W(IDX_W)) u_pick (
        .vec(left_q),
        .idx(pick_idx),
        .vld(pick_vld)
    );

    rlp_ep_src #(.DATA_W(D_W)) u_ep (
        .sel(sel_q),
        .sp_val(sp_q),
        .imm_val(immv_q),
        .ep_val(ep_out)
    );

    assign left_clr = left_q & ~(L_W'(1) << pick_idx);
    assign sp_adj   = sp_q - D_W'(imm_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (|list_mask) ? ST_PUSH : ST_ADJUST;
            end
            ST_PUSH: begin
                if (left_clr == '0) state_d = ST_ADJUST;
            end
            ST_ADJUST: state_d = ext_q ? ST_EPLOAD : ST_IDLE;
            ST_EPLOAD: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
            imm_q  <= '0;
            ext_q  <= 1'b0;
            sel_q  <= '0;
            sp_q   <= '0;
            immv_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        left_q <= list_mask;
                        imm_q  <= frame_imm;
                        ext_q  <= ext_form;
                        sel_q  <= ep_src;
                        sp_q   <= sp_in;
                        immv_q <= ext_imm;
                    end
                end
                ST_PUSH: begin
                    left_q <= left_clr;
                    sp_q   <= sp_q - D_W'(WORD_BYTES);
                end
                ST_ADJUST: sp_q <= sp_adj;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_PUSH);
        mem_addr  = sp_q - D_W'(WORD_BYTES);
        mem_wdata = rf_rdata;
        rf_raddr  = RA_W'(R_BASE) + RA_W'(pick_idx);
        sp_we     = (state_q == ST_ADJUST);
        sp_out    = sp_adj;
        ep_we     = (state_q == ST_EPLOAD);
        done      = ((state_q == ST_ADJUST) && !ext_q) || (state_q == ST_EPLOAD);
    end

    assert_write_needs_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> pick_vld);

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - D_W'(WORD_BYTES)));

    assert_push_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (rf_raddr < $past(rf_raddr)));

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, sp_we, ep_we}));

    assert_done_final_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((sp_we && !ext_q) || ep_we));

    assert_ep_after_sp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ep_we |-> $past(sp_we));

    assert_ctx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(imm_q) && $stable(ext_q) && $stable(sel_q) && $stable(immv_q)));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

// File: tb/test_reglist_push_seq.sv
`timescale 1ns/1ps
module test_reglist_push_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] list_mask = '0;
    logic [4:0]  frame_imm = '0;
    logic        ext_form = 1'b0;
    logic [1:0]  ep_src = '0;
    logic [31:0] ext_imm = '0;
    logic [31:0] sp_in = '0;
    logic [4:0]  rf_raddr;
    logic [31:0] rf_rdata;
    logic        mem_we, sp_we, ep_we, busy, done;
    logic [31:0] mem_addr, mem_wdata, sp_out, ep_out;

    typedef struct packed {
        logic [1:0]  kind;   // 0 memory write, 1 sp commit, 2 ep commit
        logic [31:0] addr;
        logic [31:0] data;
        logic        fin;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    always #2.5 clk = ~clk;

    // register-file model
    assign rf_rdata = {16'hC0DE, 11'd0, rf_raddr};

    reglist_push_seq i_reglist_push_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .list_mask(list_mask),
        .frame_imm(frame_imm), .ext_form(ext_form), .ep_src(ep_src),
        .ext_imm(ext_imm), .sp_in(sp_in), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sp_we(sp_we), .sp_out(sp_out),
        .ep_we(ep_we), .ep_out(ep_out), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // monitor: compare each strobe against the scoreboard
    always @(negedge clk) begin
        if (rst_n && (mem_we || sp_we || ep_we)) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected event", {29'd0, mem_we, sp_we, ep_we}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.kind == 2'd0) begin
                    check(mem_we, "R2 write strobe", {31'd0, mem_we}, 32'd1);
                    check(mem_addr == e.addr, "R2 write address", mem_addr, e.addr);
                    check(mem_wdata == e.data, "R3 write data/order", mem_wdata, e.data);
                end else if (e.kind == 2'd1) begin
                    check(sp_we, "R4 sp strobe", {31'd0, sp_we}, 32'd1);
                    check(sp_out == e.addr, "R4 sp value", sp_out, e.addr);
                end else begin
                    check(ep_we, "R6 ep strobe", {31'd0, ep_we}, 32'd1);
                    check(ep_out == e.data, "R7 ep value", ep_out, e.data);
                end
                check(done == e.fin, "R5 done timing", {31'd0, done}, {31'd0, e.fin});
            end
        end else if (rst_n && done) begin
            check(1'b0, "R10 stray done", 32'd1, 32'd0);
        end
    end

    task automatic run_op(input logic [11:0] m, input logic [4:0] im, input logic ex,
                          input logic [1:0] sl, input logic [31:0] sp0,
                          input logic [31:0] iv, input bit poke);
        logic [31:0] sp;
        logic [31:0] epv;
        exp_t        e;
        int          n;
        int          cyc;
        bit          fin;
        sp = sp0;
        n  = 0;
        for (int i = 11; i >= 0; i--) begin
            if (m[i]) begin
                e.kind = 2'd0;
                e.addr = sp - 32'd4;
                e.data = {16'hC0DE, 11'd0, 5'(20 + i)};
                e.fin  = 1'b0;
                exp_q.push_back(e);
                sp = sp - 32'd4;
                n++;
            end
        end
        sp = sp - {27'd0, im};
        e.kind = 2'd1; e.addr = sp; e.data = '0; e.fin = !ex;
        exp_q.push_back(e);
        if (ex) begin
            case (sl)
                2'b00:   epv = sp;
                2'b01:   epv = {{16{iv[15]}}, iv[15:0]};
                2'b10:   epv = {iv[15:0], 16'h0};
                default: epv = iv;
            endcase
            e.kind = 2'd2; e.addr = '0; e.data = epv; e.fin = 1'b1;
            exp_q.push_back(e);
        end
        @(negedge clk);
        list_mask = m; frame_imm = im; ext_form = ex; ep_src = sl;
        sp_in = sp0; ext_imm = iv; start = 1'b1;
        @(negedge clk);
        // scramble request inputs; optionally keep start high while busy (R9)
        start = poke;
        list_mask = ~m; frame_imm = ~im; ext_form = ~ex; ep_src = ~sl;
        sp_in = ~sp0; ext_imm = ~iv;
        cyc = 0;
        fin = 1'b0;
        while (!fin) begin
            if (busy) cyc++;
            fin = done;
            if (!fin) begin
                @(negedge clk);
                start = 1'b0;
            end
        end
        start = 1'b0;
        check(cyc == n + 1 + int'(ex), ex ? "R6 cycle count" : "R5 cycle count",
              32'(cyc), 32'(n + 1 + int'(ex)));
        if (m == '0) check(cyc == 1 + int'(ex), "R8 empty cycles", 32'(cyc), 32'(1 + int'(ex)));
        @(negedge clk);
        check(!busy, "R10 idle after done", {31'd0, busy}, 32'd0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({busy, done, mem_we, sp_we, ep_we} == 5'b0, "R1 reset outputs",
              {27'd0, busy, done, mem_we, sp_we, ep_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({busy, done, mem_we, sp_we, ep_we} == 5'b0, "R1 after release",
              {27'd0, busy, done, mem_we, sp_we, ep_we}, 32'd0);

        run_op(12'b1010_0000_0101, 5'd5, 1'b0, 2'b00, 32'h0000_1000, 32'h0, 1'b0); // R2 R3 R5
        run_op(12'hFFF, 5'd31, 1'b1, 2'b11, 32'h0000_2000, 32'hDEAD_BEEF, 1'b0);  // R6 R7
        run_op(12'h000, 5'd0, 1'b0, 2'b00, 32'h0000_0400, 32'h0, 1'b0);           // R8 basic
        run_op(12'h000, 5'd12, 1'b1, 2'b00, 32'h0000_0400, 32'h0, 1'b0);          // R8 extended, R7 sel 00
        run_op(12'h001, 5'd3, 1'b1, 2'b01, 32'h0000_0800, 32'h1234_8765, 1'b0);   // R7 sel 01 negative
        run_op(12'h800, 5'd1, 1'b1, 2'b10, 32'h0000_0800, 32'hAAAA_5A5A, 1'b0);   // R7 sel 10
        run_op(12'b0100_1001_0010, 5'd8, 1'b1, 2'b00, 32'h0000_0008, 32'h0, 1'b0); // R4 wrap
        run_op(12'b0011_0000_1100, 5'd4, 1'b0, 2'b00, 32'h0000_3000, 32'h0, 1'b1); // R9 start while busy
        run_op(12'h000, 5'd2, 1'b0, 2'b00, 32'h0000_3000, 32'h0, 1'b1);           // R9 one-cycle op
        run_op(12'h5A5, 5'd17, 1'b1, 2'b01, 32'h0001_0000, 32'h0000_7FFF, 1'b1);  // R9 extended

        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R5 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end
endmodule